// File: doc/BRIEF.md
# Addressed Configuration Register Bank

This block sits behind the command decoder of a serial flash slave and owns two
small register files: a volatile set and a non-volatile set of eight bytes each.
The command decoder tells it which configuration command a chip-select frame
carries and then hands over, one byte at a time, the bytes that follow the
opcode. The first bytes form an address (three or four of them, as the address
mode selects), and only that address picks a register. A write then takes one
data byte. A read returns the addressed byte on every cycle until the frame ends.

Writes are allowed only while the write-enable latch is set. Once a write
finishes, the block sends back a one-cycle request to clear that latch. Two
values are kept on outputs for the rest of the slave. The first is an
active-low octal-mode flag, taken from bit 5 of byte 0 of whichever set was
written last. The second is a dummy-cycle count, taken from volatile byte 1.
At reset both sets load the same defaults, and the octal flag is derived from
those defaults.

Top module: `flash_cfg_regs`

## Requirements
- R1: Each set holds 8 bytes, indexed by the address. A write whose full collected address (all 3 or 4 bytes) is 8 or more changes no register and leaves octal_en unchanged.
- R2: A write frame is the command, then 3 address bytes (4 when addr4 is 1 at the command), then exactly one data byte. Any byte after the data byte in the same frame is ignored.
- R3: A write command is accepted only if wel is 1 in the command cycle. Otherwise no register changes and wel_clr stays 0.
- R4: octal_en is 1 exactly when bit 5 of the last byte written to index 0 of either set is 0. It changes on the clock edge that takes that data byte.
- R5: After reset, non-volatile bytes 0 and 1 are 0xE7 and 0x1F and bytes 2 to 7 are 0xFF. The volatile set holds the same values, and octal_en is 0.
- R6: In a read frame, rd_valid is 1 from the cycle after the last address byte until cs_n goes high. In every one of those cycles rd_data is the addressed byte. rd_valid is 0 at all other times.
- R7: A read selects its register from the last (lowest) address byte only. A low byte from 8 through 255 returns 0x00.
- R8: wel_clr is 1 for exactly one cycle: the cycle after the data byte of an accepted write. This holds even when the address is out of range.
- R9: dummy_cycles equals volatile byte 1, except that the values 0x00 and 0x0F give 8.
- R10: cs_n high returns the block to idle in any phase. A write frame that ends before its data byte changes nothing.
- R11: cmd_class codes are 1 = write volatile, 2 = write non-volatile, 3 = read volatile, 4 = read non-volatile. Any other code makes the whole frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the defaults |
| cs_n | input | 1 | Frame select; high ends the current command |
| cmd_valid | input | 1 | Command class presented this cycle |
| cmd_class | input | 3 | Command code (see R11) |
| addr4 | input | 1 | 1 selects 4 address bytes, 0 selects 3 |
| byte_valid | input | 1 | byte_in carries a frame byte |
| byte_in | input | 8 | Address or data byte, most significant address byte first |
| wel | input | 1 | Write-enable latch state |
| wel_clr | output | 1 | One-cycle request to clear the latch |
| rd_valid | output | 1 | Read data phase active |
| rd_data | output | 8 | Addressed register byte |
| octal_en | output | 1 | Octal mode active |
| dummy_cycles | output | 8 | Dummy-cycle setting for fast reads |

## Verification
A write's register, octal_en and dummy_cycles change on the edge that takes the
data byte, and wel_clr is high in the single cycle that follows. The bench
therefore samples these at the falling edge one cycle after the data byte, and
again one cycle later to confirm the pulse has ended. Read data appears in the
cycle after the last address byte and repeats every cycle. Each read is sampled
over several consecutive falling edges, and rd_valid is checked low one cycle
after cs_n rises. Every sample is taken at a falling edge before that edge's
new inputs are driven.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_WR_VOL = 3'd1,
        CMD_WR_NV  = 3'd2,
        CMD_RD_VOL = 3'd3,
        CMD_RD_NV  = 3'd4
    } cmd_class_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    left;
        logic                is_nv;
        logic                is_wr;
        logic                hi_nz;
        logic [BYTE_W-1:0]   lo;
        logic                wel_clr;
    } seq_state_t;

endpackage

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq
    import cfg_regs_pkg::*;
#(
    parameter int NREGS = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_class,
    input  logic              addr4,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              wel,
    output logic              wr_vol,
    output logic              wr_nv,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wel_clr,
    output logic              rd_active,
    output logic              rd_nv,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_idx
);

    localparam logic [BYTE_W-1:0] NREGS_B = BYTE_W'(NREGS);
    localparam logic [CNT_W-1:0]  LEN3    = CNT_W'(3);
    localparam logic [CNT_W-1:0]  LEN4    = CNT_W'(4);
    localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

    seq_state_t q, d;
    logic       in_range;

    always_comb begin
        d        = q;
        d.wel_clr = 1'b0;
        wr_vol   = 1'b0;
        wr_nv    = 1'b0;
        in_range = !q.hi_nz && (q.lo < NREGS_B);
        if (cs_n) begin
            d.phase = PH_IDLE;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        d.lo    = '0;
                        d.hi_nz = 1'b0;
                        d.left  = addr4 ? LEN4 : LEN3;
                        case (cmd_class)
                            CMD_WR_VOL, CMD_WR_NV: begin
                                d.is_wr = 1'b1;
                                d.is_nv = (cmd_class == CMD_WR_NV);
                                d.phase = wel ? PH_ADDR : PH_DONE;
                            end
                            CMD_RD_VOL, CMD_RD_NV: begin
                                d.is_wr = 1'b0;
                                d.is_nv = (cmd_class == CMD_RD_NV);
                                d.phase = PH_ADDR;
                            end
                            default: d.phase = PH_DONE;
                        endcase
                    end
                end
                PH_ADDR: begin
                    if (byte_valid) begin
                        d.hi_nz = q.hi_nz | (q.lo != '0);
                        d.lo    = byte_in;
                        d.left  = q.left - ONE;
                        if (q.left == ONE) begin
                            d.phase = q.is_wr ? PH_DATA : PH_READ;
                        end
                    end
                end
                PH_DATA: begin
                    if (byte_valid) begin
                        wr_vol    = in_range && !q.is_nv;
                        wr_nv     = in_range && q.is_nv;
                        d.wel_clr = 1'b1;
                        d.phase   = PH_DONE;
                    end
                end
                default: d.phase = q.phase;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, left: '0, is_nv: 1'b0, is_wr: 1'b0,
                   hi_nz: 1'b0, lo: '0, wel_clr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wr_idx    = q.lo[IDX_W-1:0];
    assign wr_data   = byte_in;
    assign wel_clr   = q.wel_clr;
    assign rd_active = (q.phase == PH_READ);
    assign rd_nv     = q.is_nv;
    assign rd_hit    = (q.lo < NREGS_B);
    assign rd_idx    = q.lo[IDX_W-1:0];

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int NREGS = 8,
    parameter int W     = 8,
    parameter logic [NREGS*W-1:0] RST_VEC = '0,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [W-1:0]       wr_data,
    output logic [NREGS*W-1:0] regs
);

    logic [W-1:0] reg_q [NREGS];
    logic [W-1:0] reg_d [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_comb begin
            reg_d[i] = reg_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                reg_d[i] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[i] <= RST_VEC[i*W +: W];
            end else begin
                reg_q[i] <= reg_d[i];
            end
        end

        assign regs[i*W +: W] = reg_q[i];
    end

endmodule

// File: rtl/cfg_mode.sv
module cfg_mode #(
    parameter int NREGS = 8,
    parameter int W     = 8,
    parameter int OCT_BIT = 5,
    parameter logic [W-1:0] RST_B0 = 8'hE7,
    parameter logic [W-1:0] DUMMY_DFLT = 8'd8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vol,
    input  logic             wr_nv,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_oct,
    input  logic [W-1:0]     vol_b1,
    output logic             octal_en,
    output logic [W-1:0]     dummy_cycles
);

    localparam logic [W-1:0] UNSET_LO = W'(4'hF);

    logic octal_d, octal_q;

    always_comb begin
        octal_d = octal_q;
        if ((wr_vol || wr_nv) && (wr_idx == '0)) begin
            octal_d = !wr_oct;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            octal_q <= !RST_B0[OCT_BIT];
        end else begin
            octal_q <= octal_d;
        end
    end

    assign octal_en = octal_q;

    always_comb begin
        if ((vol_b1 == '0) || (vol_b1 == UNSET_LO)) begin
            dummy_cycles = DUMMY_DFLT;
        end else begin
            dummy_cycles = vol_b1;
        end
    end

endmodule

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
    import cfg_regs_pkg::*;
#(
    parameter int NREGS   = 8,
    parameter int DW      = 8,
    parameter int OCT_BIT = 5,
    parameter logic [DW-1:0] RST_B0     = 8'hE7,
    parameter logic [DW-1:0] RST_B1     = 8'h1F,
    parameter logic [DW-1:0] RST_FILL   = 8'hFF,
    parameter logic [DW-1:0] DUMMY_DFLT = 8'd8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_class,
    input  logic          addr4,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_in,
    input  logic          wel,
    output logic          wel_clr,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          octal_en,
    output logic [DW-1:0] dummy_cycles
);

    localparam int IDX_W = $clog2(NREGS);

    function automatic logic [NREGS*DW-1:0] build_rst();
        logic [NREGS*DW-1:0] v;
        for (int i = 0; i < NREGS; i++) begin
            if (i == 0)      v[i*DW +: DW] = RST_B0;
            else if (i == 1) v[i*DW +: DW] = RST_B1;
            else             v[i*DW +: DW] = RST_FILL;
        end
        return v;
    endfunction

    localparam logic [NREGS*DW-1:0] RST_VEC = build_rst();

    logic             s_wr_vol, s_wr_nv;
    logic [IDX_W-1:0] s_wr_idx, s_rd_idx;
    logic [DW-1:0]    s_wr_data;
    logic             s_rd_active, s_rd_nv, s_rd_hit;
    logic             s_wr_oct;
    logic [NREGS*DW-1:0] vol_flat, nv_flat;
    logic [DW-1:0]    sel_byte;

    cfg_cmd_seq #(.NREGS(NREGS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cmd_valid (cmd_valid),
        .cmd_class (cmd_class),
        .addr4     (addr4),
        .byte_valid(byte_valid),
        .byte_in   (byte_in),
        .wel       (wel),
        .wr_vol    (s_wr_vol),
        .wr_nv     (s_wr_nv),
        .wr_idx    (s_wr_idx),
        .wr_data   (s_wr_data),
        .wel_clr   (wel_clr),
        .rd_active (s_rd_active),
        .rd_nv     (s_rd_nv),
        .rd_hit    (s_rd_hit),
        .rd_idx    (s_rd_idx)
    );

    cfg_bank #(.NREGS(NREGS), .W(DW), .RST_VEC(RST_VEC)) u_vol (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (s_wr_vol),
        .wr_idx (s_wr_idx),
        .wr_data(s_wr_data),
        .regs   (vol_flat)
    );

    cfg_bank #(.NREGS(NREGS), .W(DW), .RST_VEC(RST_VEC)) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (s_wr_nv),
        .wr_idx (s_wr_idx),
        .wr_data(s_wr_data),
        .regs   (nv_flat)
    );

    assign s_wr_oct = s_wr_data[OCT_BIT];

    cfg_mode #(
        .NREGS     (NREGS),
        .W         (DW),
        .OCT_BIT   (OCT_BIT),
        .RST_B0    (RST_B0),
        .DUMMY_DFLT(DUMMY_DFLT)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_vol      (s_wr_vol),
        .wr_nv       (s_wr_nv),
        .wr_idx      (s_wr_idx),
        .wr_oct      (s_wr_oct),
        .vol_b1      (vol_flat[DW +: DW]),
        .octal_en    (octal_en),
        .dummy_cycles(dummy_cycles)
    );

    always_comb begin
        sel_byte = s_rd_nv ? nv_flat[s_rd_idx*DW +: DW] : vol_flat[s_rd_idx*DW +: DW];
        rd_data  = (s_rd_active && s_rd_hit) ? sel_byte : '0;
    end

    assign rd_valid = s_rd_active;

endmodule

// File: rtl/cfg_regs_chk.sv
module cfg_regs_chk #(
    parameter int DW      = 8,
    parameter int NREGS   = 8,
    parameter int OCT_BIT = 5,
    localparam int IDX_W  = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             wel_clr,
    input logic             rd_valid,
    input logic [DW-1:0]    rd_data,
    input logic             octal_en,
    input logic             wr_vol,
    input logic             wr_nv,
    input logic [IDX_W-1:0] wr_idx,
    input logic             wr_oct,
    input logic             rd_hit
);

    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_vol, wr_nv}));

    p_wel_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);

    p_wel_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vol || wr_nv) |=> wel_clr);

    p_octal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_vol || wr_nv) |=> $stable(octal_en));

    p_octal_from_b0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_vol || wr_nv) && (wr_idx == '0)) |=> (octal_en == !$past(wr_oct)));

    p_rd_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit) |-> (rd_data == '0));

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !rd_valid);

    p_abort_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(wr_vol || wr_nv));

endmodule

bind flash_cfg_regs cfg_regs_chk #(.DW(DW), .NREGS(NREGS), .OCT_BIT(OCT_BIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wel_clr (wel_clr),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .octal_en(octal_en),
    .wr_vol  (s_wr_vol),
    .wr_nv   (s_wr_nv),
    .wr_idx  (s_wr_idx),
    .wr_oct  (s_wr_oct),
    .rd_hit  (s_rd_hit)
);

// File: tb/sim_flash_cfg_regs.sv
module sim_flash_cfg_regs;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_class = 3'd0;
    logic       addr4 = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       wel = 1'b0;
    logic       wel_clr, rd_valid, octal_en;
    logic [7:0] rd_data, dummy_cycles;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [7:0] vmod [8];
    logic [7:0] nmod [8];
    logic       omod;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_class(cmd_class), .addr4(addr4), .byte_valid(byte_valid),
        .byte_in(byte_in), .wel(wel), .wel_clr(wel_clr), .rd_valid(rd_valid),
        .rd_data(rd_data), .octal_en(octal_en), .dummy_cycles(dummy_cycles)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_dummy(input logic [7:0] v);
        return ((v == 8'h00) || (v == 8'h0F)) ? 8'd8 : v;
    endfunction

    task automatic start_frame(input logic [2:0] cls, input bit a4, input bit wel_v);
        @(negedge clk);
        cs_n = 1'b0; cmd_valid = 1'b1; cmd_class = cls; addr4 = a4; wel = wel_v;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b0; byte_valid = 1'b1; byte_in = b;
    endtask

    task automatic send_addr(input logic [31:0] a, input bit a4);
        if (a4) send_byte(a[31:24]);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
    endtask

    task automatic end_frame();
        @(negedge clk);
        byte_valid = 1'b0; cmd_valid = 1'b0; cs_n = 1'b1; wel = 1'b0;
    endtask

    // cls 1 = volatile write, 2 = non-volatile write
    task automatic do_write(input bit nv, input logic [31:0] a_in, input bit a4,
                            input logic [7:0] data, input bit wel_v,
                            input bit extra, input logic [7:0] xb, input string req);
        logic [31:0] a;
        a = a4 ? a_in : (a_in & 32'h00FF_FFFF);
        start_frame(nv ? 3'd2 : 3'd1, a4, wel_v);
        send_addr(a, a4);
        send_byte(data);
        @(negedge clk);
        check({req, " R8 wel_clr pulse"}, {31'd0, wel_clr}, {31'd0, wel_v});
        byte_valid = extra; byte_in = xb;
        @(negedge clk);
        check("R8 wel_clr single cycle", {31'd0, wel_clr}, 32'd0);
        byte_valid = 1'b0; cs_n = 1'b1; wel = 1'b0;
        if (wel_v && (a < 32'd8)) begin
            if (nv) nmod[a[2:0]] = data; else vmod[a[2:0]] = data;
            if (a[2:0] == 3'd0) omod = ~data[5];
        end
        @(negedge clk);
        check({req, " R4 octal_en"}, {31'd0, octal_en}, {31'd0, omod});
        check({req, " R9 dummy_cycles"}, {24'd0, dummy_cycles}, {24'd0, exp_dummy(vmod[1])});
    endtask

    task automatic do_read(input bit nv, input logic [31:0] a_in, input bit a4,
                           input int ncyc, input string req);
        logic [31:0] a;
        logic [7:0]  exp;
        a = a4 ? a_in : (a_in & 32'h00FF_FFFF);
        exp = (a[7:0] < 8'd8) ? (nv ? nmod[a[2:0]] : vmod[a[2:0]]) : 8'h00;
        start_frame(nv ? 3'd4 : 3'd3, a4, 1'b0);
        send_addr(a, a4);
        @(negedge clk);
        byte_valid = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            if (k != 0) @(negedge clk);
            check({req, " R6 rd_valid"}, {31'd0, rd_valid}, 32'd1);
            check({req, " rd_data"}, {24'd0, rd_data}, {24'd0, exp});
        end
        end_frame();
        @(negedge clk);
        check("R6 R10 rd_valid after frame", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic read_all(input string req);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 8; i++) begin
                do_read(b[0], 32'(i), i[0], 2, req);
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            nmod[i] = (i == 0) ? 8'hE7 : (i == 1) ? 8'h1F : 8'hFF;
            vmod[i] = nmod[i];
        end
        omod = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state
        check("R5 rd_valid idle", {31'd0, rd_valid}, 32'd0);
        check("R5 wel_clr idle", {31'd0, wel_clr}, 32'd0);
        check("R5 octal_en", {31'd0, octal_en}, 32'd0);
        check("R5 R9 dummy_cycles", {24'd0, dummy_cycles}, 32'h1F);
        read_all("R5 reset contents");

        // R1 R2: sweep every index of both sets, 3 and 4 address bytes
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 8; i++) begin
                do_write(b[0], 32'(i), ~i[0], 8'(b * 8'h40 + i * 8'h13 + 8'h21),
                         1'b1, 1'b0, 8'h00, "R1 R2 sweep");
            end
        end
        read_all("R1 sweep readback");

        // R4: octal mode from byte 0 of either set
        do_write(1'b1, 32'd0, 1'b0, 8'hC7, 1'b1, 1'b0, 8'h00, "R4 nv b0 bit5=0");
        do_write(1'b0, 32'd0, 1'b1, 8'hFF, 1'b1, 1'b0, 8'h00, "R4 vol b0 bit5=1");
        do_write(1'b0, 32'd0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, "R4 vol b0 zero");
        do_write(1'b1, 32'd3, 1'b0, 8'hFF, 1'b1, 1'b0, 8'h00, "R4 nv b3 no effect");

        // R9: dummy-cycle substitution
        do_write(1'b0, 32'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, "R9 b1=00");
        do_write(1'b0, 32'd1, 1'b0, 8'h0F, 1'b1, 1'b0, 8'h00, "R9 b1=0F");
        do_write(1'b0, 32'd1, 1'b0, 8'h0A, 1'b1, 1'b0, 8'h00, "R9 b1=0A");
        do_write(1'b0, 32'd1, 1'b1, 8'hF0, 1'b1, 1'b0, 8'h00, "R9 b1=F0");
        do_write(1'b1, 32'd1, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, "R9 nv b1 no effect");

        // R3: no write-enable
        do_write(1'b0, 32'd2, 1'b0, 8'h99, 1'b0, 1'b0, 8'h00, "R3 no wel vol");
        do_write(1'b1, 32'd0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R3 no wel nv b0");
        do_read(1'b0, 32'd2, 1'b0, 2, "R3 readback");

        // R1: out-of-range writes
        do_write(1'b1, 32'd8, 1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, "R1 addr 8");
        do_write(1'b1, 32'h0000_0103, 1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, "R1 addr 0x103");
        do_write(1'b0, 32'h0100_0000, 1'b1, 8'h5A, 1'b1, 1'b0, 8'h00, "R1 addr 4-byte high");
        do_write(1'b1, 32'hFF, 1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, "R1 addr 0xFF");
        read_all("R1 after out-of-range");

        // R7: read uses low byte only
        do_read(1'b1, 32'h0000_0103, 1'b0, 3, "R7 hi nonzero low 3");
        do_read(1'b0, 32'hAB00_0006, 1'b1, 3, "R7 4-byte low 6");
        do_read(1'b1, 32'd8, 1'b0, 3, "R7 low 8");
        do_read(1'b0, 32'h55, 1'b1, 3, "R7 low 0x55");
        do_read(1'b1, 32'hFF, 1'b0, 3, "R7 low 0xFF");

        // R2: byte after data ignored
        do_write(1'b0, 32'd5, 1'b0, 8'h3C, 1'b1, 1'b1, 8'hC3, "R2 extra byte");
        do_read(1'b0, 32'd5, 1'b0, 4, "R2 readback");

        // R11: unknown command code
        start_frame(3'd6, 1'b0, 1'b1);
        send_addr(32'd4, 1'b0);
        send_byte(8'h11);
        @(negedge clk);
        check("R11 unknown code wel_clr", {31'd0, wel_clr}, 32'd0);
        check("R11 unknown code rd_valid", {31'd0, rd_valid}, 32'd0);
        end_frame();
        do_read(1'b0, 32'd4, 1'b0, 2, "R11 readback");

        // R10: frame ended before data byte
        start_frame(3'd2, 1'b0, 1'b1);
        send_addr(32'd2, 1'b0);
        end_frame();
        @(negedge clk);
        check("R10 abort wel_clr", {31'd0, wel_clr}, 32'd0);
        cs_n = 1'b0; byte_valid = 1'b1; byte_in = 8'h77;
        @(negedge clk);
        check("R10 stray byte wel_clr", {31'd0, wel_clr}, 32'd0);
        byte_valid = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        do_read(1'b1, 32'd2, 1'b0, 2, "R10 readback");
        check("R10 octal_en unchanged", {31'd0, octal_en}, {31'd0, omod});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule